// File: doc/BRIEF.md
# Interrupt request capture stage

This block is the front end of a programmable interrupt controller. It watches eight active-high request lines and keeps a request latch for each one. It presents the latched requests, gated by a per-line enable, as a registered pending vector. A priority resolver further down the chip reads that vector.

A single mode input selects how requests are taken:
- **Edge-triggered.** A synchronized low-to-high transition sets the latch. It only does so while the line's edge-sense latch is armed. That latch re-arms only after the line has been seen low.
- **Level-sensitive.** The latch follows the synchronized input for as long as the line is not in service.

The controller reports a serviced level with a one-cycle acknowledge strobe and a level index. It ends service on a line with a per-line in-service clear.

All inputs are plain control pins sampled on every clock. There is no valid/ready stream at this boundary, so nothing here applies back-pressure. The acknowledge is a strobe that the block always accepts in the cycle it is presented.

Top module: `irq_req_capture`

## Requirements
- R1: Every request line passes through a two-flop synchronizer. Suppose `req_in` changes before rising edge k. Then `pending` reflects the change after edge k+2 and not earlier.
- R2: With `level_mode`=0, a synchronized rise on line i sets request latch i, provided its edge-sense latch is armed. The latch, and so `pending[i]`, stays set after the input falls, until line i is acknowledged.
- R3: An edge where `ack_valid`=1 and `ack_level`=i does three things at once: it clears request latch i, it clears `pending[i]`, and it disarms edge-sense latch i. Other lines are unaffected. The acknowledge wins over a new request on that same edge. In edge mode, a line held high across its acknowledge raises nothing more until it has been low and rises again.
- R4: With `level_mode`=1 and line i not in service, request latch i equals the synchronized input. A line that drops before it is acknowledged withdraws its request after the R1 latency.
- R5: An acknowledge of line i sets its in-service bit, and `isr_clear[i]`=1 clears it. In level mode, no request is latched on line i while that bit is set. If the synchronized input is still high at the edge where `isr_clear[i]` is applied, `pending[i]` rises after that same edge.
- R6: Any change of `level_mode` disarms every edge-sense latch at that edge, and this disarm wins over re-arming. An edge-mode rise that is synchronized on the very next edge is therefore not taken.
- R7: `pending[i]` is the registered AND of request latch i and `enable[i]`. Here `enable[i]`=0 masks the line. A masked request stays latched and appears one edge after `enable[i]` returns to 1.
- R8: `rst`=1 is synchronous and does the following on the next edge:
  - clears `pending`, every request latch, every in-service bit and the synchronizer;
  - arms every edge-sense latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_mode | input | 1 | Trigger mode: 0 edge, 1 level |
| req_in | input | 8 | Raw request lines, active high |
| enable | input | 8 | Per-line enable; 0 masks the line from `pending` |
| ack_valid | input | 1 | Acknowledge strobe, one cycle per serviced level |
| ack_level | input | 3 | Index of the acknowledged level |
| isr_clear | input | 8 | Per-line in-service clear |
| pending | output | 8 | Registered pending-request vector |

## Verification
Directed request waveforms cover the following distinctions:
- A pulse that falls before its acknowledge separates edge mode, where it is kept, from level mode, where it is withdrawn.
- A line held high across its acknowledge separates a correct re-arm from one that re-requests at once.
- A level-mode line held through service, then released with an in-service clear, shows whether the re-request appears on the clearing edge.
- A mode switch timed one edge before a synchronized rise shows whether the disarm on a mode change takes precedence.

Random toggling of lines, acknowledges, clears, enables and mode is then compared cycle by cycle against a bench model, to catch wrong ordering between simultaneous events.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic req;
    logic armed;
    logic in_svc;
  } lane_state_t;

  localparam lane_state_t LANE_RESET = '{req: 1'b0, armed: 1'b1, in_svc: 1'b0};
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_ack_decode.sv
module irqc_ack_decode #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     hit
);
  for (genvar gi = 0; gi < N; gi++) begin : g_hit
    assign hit[gi] = valid && (idx == IDX_W'(gi));
  end
endmodule

// File: rtl/irqc_lane.sv
module irqc_lane
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic level_mode,
  input  logic disarm,
  input  logic s_now,
  input  logic ack_hit,
  input  logic svc_clr,
  input  logic enable,
  output logic req,
  output logic armed,
  output logic in_svc,
  output logic pend
);
  lane_state_t st_q, st_d;
  logic        s_prev_q;
  logic        pend_q;
  logic        rise;
  logic        svc_held;
  trig_mode_e  mode;

  assign mode     = trig_mode_e'(level_mode);
  assign rise     = s_now & ~s_prev_q;
  assign svc_held = st_q.in_svc & ~svc_clr;

  always_comb begin
    st_d.in_svc = svc_held | ack_hit;

    // Disarm (mode change or acknowledge) takes precedence over re-arm.
    if (disarm || ack_hit)  st_d.armed = 1'b0;
    else if (!s_now)        st_d.armed = 1'b1;
    else                    st_d.armed = st_q.armed;

    if (ack_hit)                 st_d.req = 1'b0;
    else if (mode == TRIG_LEVEL) st_d.req = s_now & ~svc_held;
    else                         st_d.req = st_q.req | (st_q.armed & rise);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= LANE_RESET;
      s_prev_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      s_prev_q <= s_now;
      pend_q   <= st_d.req & enable;
    end
  end

  assign req    = st_q.req;
  assign armed  = st_q.armed;
  assign in_svc = st_q.in_svc;
  assign pend   = pend_q;
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int NUM_LEVELS  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  level_mode,
  input  logic [NUM_LEVELS-1:0] req_in,
  input  logic [NUM_LEVELS-1:0] enable,
  input  logic                  ack_valid,
  input  logic [IDX_W-1:0]      ack_level,
  input  logic [NUM_LEVELS-1:0] isr_clear,
  output logic [NUM_LEVELS-1:0] pending
);
  logic [NUM_LEVELS-1:0] sync_now;
  logic [NUM_LEVELS-1:0] ack_vec;
  logic [NUM_LEVELS-1:0] req_vec;
  logic [NUM_LEVELS-1:0] armed_vec;
  logic [NUM_LEVELS-1:0] svc_vec;
  logic                  mode_q;
  logic                  mode_flip;

  irqc_sync #(.WIDTH(NUM_LEVELS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_in),
    .q   (sync_now)
  );

  irqc_ack_decode #(.N(NUM_LEVELS), .IDX_W(IDX_W)) u_ack (
    .valid (ack_valid),
    .idx   (ack_level),
    .hit   (ack_vec)
  );

  always_ff @(posedge clk) mode_q <= level_mode;
  assign mode_flip = level_mode ^ mode_q;

  for (genvar gi = 0; gi < NUM_LEVELS; gi++) begin : g_lane
    irqc_lane u_lane (
      .clk        (clk),
      .rst        (rst),
      .level_mode (level_mode),
      .disarm     (mode_flip),
      .s_now      (sync_now[gi]),
      .ack_hit    (ack_vec[gi]),
      .svc_clr    (isr_clear[gi]),
      .enable     (enable[gi]),
      .req        (req_vec[gi]),
      .armed      (armed_vec[gi]),
      .in_svc     (svc_vec[gi]),
      .pend       (pending[gi])
    );
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             level_mode,
  input logic             ack_valid,
  input logic [IDX_W-1:0] ack_level,
  input logic [N-1:0]     enable,
  input logic [N-1:0]     isr_clear,
  input logic [N-1:0]     pending,
  input logic [N-1:0]     req_vec,
  input logic [N-1:0]     armed_vec,
  input logic [N-1:0]     svc_vec,
  input logic [N-1:0]     sync_now,
  input logic [N-1:0]     ack_vec
);
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (pending == '0 && req_vec == '0)); // R8

  AST_NEW_REQ_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((req_vec & ~$past(req_vec) & ~$past(sync_now)) == '0)); // R1

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!rst && !level_mode) |=> (($past(req_vec) & ~$past(ack_vec) & ~req_vec) == '0)); // R2

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!rst && ack_valid) |=> !pending[$past(ack_level)]); // R3

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!rst && level_mode) |=> ((req_vec & ~$past(sync_now)) == '0)); // R4

  AST_SVC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!rst && level_mode) |=> ((req_vec & $past(svc_vec) & ~$past(isr_clear)) == '0)); // R5

  AST_EDGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    (!rst && !level_mode) |=> ((req_vec & ~$past(req_vec) & ~$past(armed_vec)) == '0)); // R6

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pending & ~$past(enable)) == '0)); // R7
endmodule

bind irq_req_capture irqc_checker #(.N(NUM_LEVELS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .level_mode (level_mode),
  .ack_valid  (ack_valid),
  .ack_level  (ack_level),
  .enable     (enable),
  .isr_clear  (isr_clear),
  .pending    (pending),
  .req_vec    (req_vec),
  .armed_vec  (armed_vec),
  .svc_vec    (svc_vec),
  .sync_now   (sync_now),
  .ack_vec    (ack_vec)
);

// File: tb/sim_irq_req_capture.sv
`timescale 1ns/1ps
module sim_irq_req_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       level_mode = 1'b0;
  logic [7:0] req_in = '0;
  logic [7:0] enable = '1;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_level = '0;
  logic [7:0] isr_clear = '0;
  logic [7:0] pending;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Bench reference state, built from the requirements.
  logic [7:0] m_s1, m_s2, m_prev, m_req, m_arm, m_ins, m_pend;
  logic       m_mode;

  always #4 clk = ~clk;

  irq_req_capture u0 (
    .clk        (clk),
    .rst        (rst),
    .level_mode (level_mode),
    .req_in     (req_in),
    .enable     (enable),
    .ack_valid  (ack_valid),
    .ack_level  (ack_level),
    .isr_clear  (isr_clear),
    .pending    (pending)
  );

  task automatic model_step();
    logic [7:0] ackv, held, nreq, narm;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_req = '0;
      m_arm = '1; m_ins = '0; m_pend = '0; m_mode = level_mode;
    end else begin
      ackv = ack_valid ? (8'b1 << ack_level) : 8'h00;
      held = m_ins & ~isr_clear;
      if (level_mode) nreq = m_s2 & ~held;                     // R4, R5
      else            nreq = m_req | (m_arm & m_s2 & ~m_prev); // R2
      nreq = nreq & ~ackv;                                     // R3
      narm = m_arm | ~m_s2;
      if (level_mode != m_mode) narm = '0;                     // R6
      narm = narm & ~ackv;
      m_pend = nreq & enable;                                  // R7
      m_prev = m_s2; m_s2 = m_s1; m_s1 = req_in;               // R1
      m_req = nreq; m_arm = narm; m_ins = held | ackv; m_mode = level_mode;
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(level_mode ? "R4 model" : "R2 model", pending, m_pend);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ack(input int lvl);
    ack_valid = 1'b1; ack_level = 3'(lvl);
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(3);
    rst = 1'b0;
    tick();
    check("R8 reset", pending, 8'h00);

    // R1: latency of two sync flops plus the registered output
    req_in[3] = 1'b1;
    ticks(2); check("R1 early", {7'b0, pending[3]}, 8'h00);
    tick();   check("R1 on time", {7'b0, pending[3]}, 8'h01);

    // R2: edge request survives the input falling
    req_in[3] = 1'b0;
    ticks(4); check("R2 sticky", {7'b0, pending[3]}, 8'h01);

    // R3: ack clears; a held line must re-arm first
    ack(3); check("R3 ack", {7'b0, pending[3]}, 8'h00);
    req_in[5] = 1'b1; ticks(3);
    ack(5); ticks(5); check("R3 held", {7'b0, pending[5]}, 8'h00);
    req_in[5] = 1'b0; ticks(3);
    req_in[5] = 1'b1; ticks(3); check("R3 rearm", {7'b0, pending[5]}, 8'h01);
    ack(5); req_in[5] = 1'b0;
    isr_clear = '1; tick(); isr_clear = '0;

    // R7: masked request stays latched
    enable[1] = 1'b0; req_in[1] = 1'b1;
    ticks(4); check("R7 masked", {7'b0, pending[1]}, 8'h00);
    enable[1] = 1'b1;
    tick(); check("R7 unmasked", {7'b0, pending[1]}, 8'h01);
    ack(1); req_in[1] = 1'b0; ticks(3);

    // R4: level mode follows the input
    level_mode = 1'b1; tick();
    req_in[2] = 1'b1; ticks(3); check("R4 high", {7'b0, pending[2]}, 8'h01);
    req_in[2] = 1'b0; ticks(3); check("R4 withdraw", {7'b0, pending[2]}, 8'h00);

    // R5: in-service blocks, clear re-raises at once
    req_in[6] = 1'b1; ticks(3);
    ack(6); ticks(4); check("R5 blocked", {7'b0, pending[6]}, 8'h00);
    isr_clear[6] = 1'b1; tick(); isr_clear = '0;
    check("R5 reraise", {7'b0, pending[6]}, 8'h01);
    ack(6); req_in[6] = 1'b0;
    isr_clear = '1; tick(); isr_clear = '0; ticks(3);

    // R6: mode change one edge before a synchronized rise
    req_in[4] = 1'b1; tick();
    level_mode = 1'b0; ticks(4);
    check("R6 disarmed", {7'b0, pending[4]}, 8'h00);
    req_in[4] = 1'b0; ticks(3);
    req_in[4] = 1'b1; ticks(3);
    check("R6 rearmed", {7'b0, pending[4]}, 8'h01);
    ack(4); req_in = '0;
    isr_clear = '1; tick(); isr_clear = '0;

    // Random phase compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 8; b++) if ($urandom_range(7) == 0) req_in[b] = ~req_in[b];
      ack_valid = ($urandom_range(5) == 0);
      ack_level = 3'($urandom_range(7));
      isr_clear = ($urandom_range(3) == 0) ? 8'($urandom) : 8'h00;
      enable    = ($urandom_range(9) == 0) ? 8'($urandom) : 8'hFF;
      if ($urandom_range(149) == 0) level_mode = ~level_mode;
      tick();
    end
    ack_valid = 1'b0;
    finish_run();
  end
endmodule